// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block is the protection and status core of a small serial EEPROM with a 128-byte array. A command decoder in front of it turns serial traffic into one-cycle strobes. The strobes are: set the enable latch, clear the enable latch, read status, write status, and array write with a 7-bit address. The block also watches the active-low write-protect pin. It keeps three pieces of state: the busy flag, the write-enable latch and the two block-protect bits.

For every array or status write request, the block answers with a one-cycle grant or deny pulse in the following cycle. A granted write puts the controller into its busy state for a fixed, parameterised number of cycles. While busy, the only command the block acts on is a status read. When the timed write finishes, the enable latch is dropped. A status read returns the status byte one cycle after the request.

The controller is a two-state machine. The states are `ST_IDLE` and `ST_BUSY`. There are two transitions:
- *launch* takes `ST_IDLE` to `ST_BUSY` when a write request is granted.
- *expire* takes `ST_BUSY` back to `ST_IDLE` when the busy timer reaches its final count.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset, busy is 0, the enable latch is 0, the protect bits are 00, grant, deny and status_valid are 0, and a status read returns 8'h00.
- R2: A status read returns, in the next cycle with status_valid high, the byte {4'b0000, protect[1:0], latch, busy}. Bit 0 is busy, bit 1 is the enable latch, bit 2 is the low protect bit and bit 3 is the high protect bit. The byte reflects the state before the edge that sampled the request, and bits 7:4 always read 0.
- R3: The enable latch is set only by `cmd_wren`, only in `ST_IDLE`, and only while `wp_n` is high.
- R4: The enable latch clears in four cases: on `cmd_wrdi` in `ST_IDLE`, on a granted status write, on the *expire* transition, and in every cycle `wp_n` is low.
- R5: A status write is granted only when the latch is 1, `wp_n` is high and the state is `ST_IDLE`. A granted status write loads the protect bits from `sr_wdata[3:2]` and discards bits 7:4 and 1:0.
- R6: An array write is granted only when the latch is 1, `wp_n` is high, the state is `ST_IDLE` and the address lies outside the protected range. The protected range depends on the protect bits: 00 protects no address, 01 protects 60h–7Fh, 10 protects 40h–7Fh, and 11 protects 00h–7Fh.
- R7: Every write request produces exactly one of grant or deny, as a one-cycle pulse in the next cycle. If `cmd_wrsr` and `cmd_write` coincide, they form one request and the status write takes precedence.
- R8: A granted write raises busy in the same cycle as grant, and busy stays high for exactly BUSY_CYCLES cycles.
- R9: While busy, the block ignores enable-latch commands and denies write requests. Status reads are still served.
- R10: A refused write changes no state: the enable latch, the protect bits and busy all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin; low forbids writes and clears the latch |
| cmd_wren | input | 1 | Strobe: set the enable latch |
| cmd_wrdi | input | 1 | Strobe: clear the enable latch |
| cmd_rdsr | input | 1 | Strobe: read status |
| cmd_wrsr | input | 1 | Strobe: write status |
| sr_wdata | input | 8 | Data byte for a status write |
| cmd_write | input | 1 | Strobe: array write request |
| wr_addr | input | ADDR_W | Array address of the write request |
| grant | output | 1 | One-cycle pulse: last write request accepted |
| deny | output | 1 | One-cycle pulse: last write request refused |
| busy | output | 1 | Timed write in progress |
| status_valid | output | 1 | status_out carries a requested status byte |
| status_out | output | 8 | Status byte |

## Verification
Two events can meet in one cycle: the *expire* transition, and a command arriving on the very edge where the timer finishes. The bench drives a write and waits BUSY_CYCLES-1 idle cycles. It then places an enable command on the final busy edge. A status read afterwards must show the latch still clear, because the state was still `ST_BUSY` when the command was sampled. A second meeting comes from lowering `wp_n` in the same cycle as an enable command. The latch must stay 0 in that case. Both situations also arise in the long random phase, where a behavioural reference model is compared against the outputs on every clock.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } wpc_state_e;

    localparam int unsigned STATUS_W = 8;

    function automatic logic [STATUS_W-1:0] pack_status(
        input logic [1:0] prot,
        input logic       latch,
        input logic       bsy
    );
        return {4'b0000, prot, latch, bsy};
    endfunction
endpackage

// File: rtl/wpc_range_guard.sv
module wpc_range_guard #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic [1:0]        prot,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int unsigned DEPTH   = 1 << ADDR_W;
    localparam int unsigned QUARTER = DEPTH / 4;

    logic [ADDR_W:0] low_bound;

    always_comb begin
        unique case (prot)
            2'b00:   low_bound = (ADDR_W+1)'(DEPTH);
            2'b01:   low_bound = (ADDR_W+1)'(DEPTH - QUARTER);
            2'b10:   low_bound = (ADDR_W+1)'(DEPTH - 2*QUARTER);
            default: low_bound = '0;
        endcase
    end

    assign locked = ({1'b0, addr} >= low_bound);
endmodule

// File: rtl/wpc_busy_timer.sv
module wpc_busy_timer #(
    parameter int unsigned BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic running,
    output logic expire
);
    localparam int unsigned CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_VAL;
        end else if (running && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = running && (cnt_q == '0);
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
    import wpc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned BUSY_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wp_n,
    input  logic                cmd_wren,
    input  logic                cmd_wrdi,
    input  logic                cmd_rdsr,
    input  logic                cmd_wrsr,
    input  logic [7:0]          sr_wdata,
    input  logic                cmd_write,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic                grant,
    output logic                deny,
    output logic                busy,
    output logic                status_valid,
    output logic [STATUS_W-1:0] status_out
);
    wpc_state_e state_q, state_d;

    logic       wel_q, wel_d;
    logic [1:0] bp_q;
    logic       grant_q, deny_q, sv_q;
    logic [STATUS_W-1:0] st_q;

    logic in_idle, addr_locked, expire;
    logic req_sr, req_wr, any_req;
    logic gate_open, take_sr, take_wr, launch;
    logic unused_bits;

    assign unused_bits = ^{sr_wdata[7:4], sr_wdata[1:0]};

    wpc_range_guard #(.ADDR_W(ADDR_W)) u_guard (
        .prot   (bp_q),
        .addr   (wr_addr),
        .locked (addr_locked)
    );

    wpc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (launch),
        .running (state_q == ST_BUSY),
        .expire  (expire)
    );

    assign in_idle   = (state_q == ST_IDLE);
    assign req_sr    = cmd_wrsr;
    assign req_wr    = cmd_write && !cmd_wrsr;
    assign any_req   = req_sr || req_wr;
    assign gate_open = wel_q && wp_n && in_idle;
    assign take_sr   = req_sr && gate_open;
    assign take_wr   = req_wr && gate_open && !addr_locked;
    assign launch    = take_sr || take_wr;

    // Next-state logic: launch and expire transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_BUSY;
            ST_BUSY: if (expire) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Enable latch update
    always_comb begin
        wel_d = wel_q;
        if (expire) begin
            wel_d = 1'b0;
        end else if (in_idle) begin
            if (take_sr)                  wel_d = 1'b0;
            else if (any_req)             wel_d = wel_q;
            else if (cmd_wrdi)            wel_d = 1'b0;
            else if (cmd_wren)            wel_d = 1'b1;
        end
        if (!wp_n) wel_d = 1'b0;
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wel_q   <= 1'b0;
            bp_q    <= 2'b00;
        end else begin
            state_q <= state_d;
            wel_q   <= wel_d;
            if (take_sr) bp_q <= sr_wdata[3:2];
        end
    end

    // Output register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
            sv_q    <= 1'b0;
            st_q    <= '0;
        end else begin
            grant_q <= launch;
            deny_q  <= any_req && !launch;
            sv_q    <= cmd_rdsr;
            if (cmd_rdsr) st_q <= pack_status(bp_q, wel_q, state_q == ST_BUSY);
        end
    end

    assign grant        = grant_q;
    assign deny         = deny_q;
    assign busy         = (state_q == ST_BUSY);
    assign status_valid = sv_q;
    assign status_out   = sv_q ? st_q : '0;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int unsigned BUSY_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       cmd_wrsr,
    input logic       cmd_write,
    input logic       grant,
    input logic       deny,
    input logic       busy,
    input logic       status_valid,
    input logic [7:0] status_out,
    input logic       wel_q,
    input logic [1:0] bp_q
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= 0;
        else if (busy)  run_len <= run_len + 1;
        else            run_len <= 0;
    end

    p_one_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));

    p_req_answered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr || cmd_write) |=> (grant || deny));

    p_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy);

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == BUSY_CYCLES));

    p_busy_denies_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmd_wrsr || cmd_write)) |=> deny);

    p_wp_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !wel_q);

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> (status_out[7:4] == 4'b0000));

    p_deny_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        deny |-> $stable(bp_q));
endmodule

bind eeprom_wp_ctrl wpc_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_wpc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_n         (wp_n),
    .cmd_wrsr     (cmd_wrsr),
    .cmd_write    (cmd_write),
    .grant        (grant),
    .deny         (deny),
    .busy         (busy),
    .status_valid (status_valid),
    .status_out   (status_out),
    .wel_q        (wel_q),
    .bp_q         (bp_q)
);

// File: tb/eeprom_wp_ctrl_test.sv
module eeprom_wp_ctrl_test;
    localparam int BC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_rdsr = 0, cmd_wrsr = 0, cmd_write = 0;
    logic [7:0] sr_wdata = '0;
    logic [6:0] wr_addr = '0;
    logic grant, deny, busy, status_valid;
    logic [7:0] status_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    eeprom_wp_ctrl #(.ADDR_W(7), .BUSY_CYCLES(BC)) uut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_rdsr(cmd_rdsr),
        .cmd_wrsr(cmd_wrsr), .sr_wdata(sr_wdata), .cmd_write(cmd_write),
        .wr_addr(wr_addr), .grant(grant), .deny(deny), .busy(busy),
        .status_valid(status_valid), .status_out(status_out)
    );

    always #5 clk = ~clk;

    // Reference model
    int         m_left = 0;
    logic       m_wel = 0;
    logic [1:0] m_bp = 0;
    logic       e_grant = 0, e_deny = 0, e_sv = 0;
    logic [7:0] e_st = 0;

    function automatic logic in_prot(input logic [1:0] bp, input logic [6:0] a);
        int ai;
        ai = a;
        if (bp == 2'd3) return 1'b1;
        if (bp == 2'd2) return ai >= 64;
        if (bp == 2'd1) return ai >= 96;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_wel = 0; m_bp = 0;
            e_grant = 0; e_deny = 0; e_sv = 0; e_st = 0;
        end else begin
            logic bsy, req, ok, nw;
            bsy = (m_left > 0);
            e_sv = cmd_rdsr;
            e_st = cmd_rdsr ? {4'b0, m_bp, m_wel, bsy} : 8'h00;
            req = cmd_wrsr || cmd_write;
            if (bsy || !m_wel || !wp_n) ok = 0;
            else if (cmd_wrsr) ok = 1;
            else ok = !in_prot(m_bp, wr_addr);
            e_grant = req && ok;
            e_deny  = req && !ok;
            nw = m_wel;
            if (bsy) begin
                if (m_left == 1) nw = 0;
                m_left = m_left - 1;
            end else if (e_grant) begin
                m_left = BC;
                if (cmd_wrsr) begin
                    m_bp = sr_wdata[3:2];
                    nw = 0;
                end
            end else if (!req) begin
                if (cmd_wrdi) nw = 0;
                else if (cmd_wren) nw = 1;
            end
            if (!wp_n) nw = 0;
            m_wel = nw;
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(busy == (m_left > 0), "R8", "busy", busy, m_left > 0);
            check(grant == e_grant && deny == e_deny, "R7", "grant/deny",
                  {grant, deny}, {e_grant, e_deny});
            check(status_valid == e_sv, "R2", "status_valid", status_valid, e_sv);
            if (e_sv) check(status_out == e_st, "R2", "status_out", status_out, e_st);
        end
    end

    task automatic drive(input bit en, input bit dis, input bit rd, input bit ws,
                         input bit wr, input logic [7:0] d, input logic [6:0] a,
                         input bit wp);
        @(negedge clk);
        cmd_wren = en; cmd_wrdi = dis; cmd_rdsr = rd; cmd_wrsr = ws;
        cmd_write = wr; sr_wdata = d; wr_addr = a; wp_n = wp;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 8'h00, 7'h00, 1);
    endtask

    task automatic rd_expect(input logic [7:0] exp, input string req);
        drive(0, 0, 1, 0, 0, 8'h00, 7'h00, 1);
        idle();
        check(status_valid && status_out == exp, req, "status", status_out, exp);
    endtask

    task automatic wr_expect(input logic [6:0] a, input bit exp_grant, input string req);
        drive(0, 0, 0, 0, 1, 8'h00, a, 1);
        idle();
        check(grant == exp_grant && deny == !exp_grant, req, "array write",
              {grant, deny}, {exp_grant, !exp_grant});
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4 * BC && busy; i++) idle();
    endtask

    task automatic set_bp(input logic [7:0] d);
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        drive(0, 0, 0, 1, 0, d, 7'h00, 1);
        idle();
        check(grant && !deny, "R5", "status write grant", {grant, deny}, 2'b10);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        check(!busy && !grant && !deny && !status_valid, "R1", "idle outputs",
              {busy, grant, deny, status_valid}, 0);
        rd_expect(8'h00, "R1");

        // R3: set blocked by WP low, same cycle
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 0);
        rd_expect(8'h00, "R3");
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        rd_expect(8'h02, "R3");

        // R4: clear paths
        drive(0, 1, 0, 0, 0, 8'h00, 7'h00, 1);
        rd_expect(8'h00, "R4");
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        drive(0, 0, 0, 0, 0, 8'h00, 7'h00, 0);
        rd_expect(8'h00, "R4");

        // R10: refused status write without latch
        drive(0, 0, 0, 1, 0, 8'hFC, 7'h00, 1);
        idle();
        check(deny && !grant, "R10", "status write refused", {grant, deny}, 2'b01);
        rd_expect(8'h00, "R10");

        // R5: status write loads bits 3:2 only, clears latch
        set_bp(8'hF7);
        rd_expect(8'h04, "R5");

        // R6 with protect 01
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        wr_expect(7'h60, 0, "R6");
        rd_expect(8'h06, "R10");
        drive(0, 0, 0, 0, 1, 8'h00, 7'h5F, 1);
        idle();
        check(grant && busy, "R6", "write below 60h", {grant, busy}, 2'b11);

        // R9: ignored commands while busy
        drive(0, 1, 0, 0, 0, 8'h00, 7'h00, 1);
        rd_expect(8'h07, "R9");
        wr_expect(7'h00, 0, "R9");
        wait_done();
        rd_expect(8'h04, "R4");

        // Command exactly on the expire edge
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        drive(0, 0, 0, 0, 1, 8'h00, 7'h10, 1);
        for (int i = 0; i < BC - 1; i++) idle();
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        rd_expect(8'h04, "R9");

        // Protect 11 and 10
        set_bp(8'h0C);
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        wr_expect(7'h00, 0, "R6");
        set_bp(8'h08);
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        wr_expect(7'h40, 0, "R6");
        wr_expect(7'h3F, 1, "R6");
        wait_done();
        set_bp(8'h00);
        drive(1, 0, 0, 0, 0, 8'h00, 7'h00, 1);
        wr_expect(7'h7F, 1, "R6");
        wait_done();

        // Random phase, model compared every clock
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = $urandom % 7;
            drive(op == 0 || op == 5, op == 1, ($urandom % 3) == 0, op == 2, op == 3,
                  8'($urandom), 7'($urandom), ($urandom % 16) != 0);
        end
        idle();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule